// File: doc/BRIEF.md
# Streaming and Stride Cache Prefetcher

This block observes the demand loads of a core and proposes cache lines to fetch before they are requested. Each demand access carries a byte address and the instruction pointer (IP) of the load that issued it. Two detectors run side by side on every access, and their proposals go to a small queue that a cache controller drains.

The window detector tracks one 4 KiB-aligned address window. It waits until several accesses have climbed through that window in ascending line order. From then on, each further ascending access requests the next two cache lines. The stride detector keeps a small table indexed by the low IP bits. It learns the distance between successive accesses from the same IP and, once it is confident, predicts the line that follows. A proposal that repeats a recently queued line is discarded. When the queue is full, proposals are thrown away, so demand traffic never waits.

The demand side has only a valid strobe. An access presented with `acc_valid` high is taken in that cycle and cannot be refused. The prefetch side is a valid/ready stream. `pf_line` is presented while `pf_valid` is high. It is consumed on a clock edge where `pf_ready` is also high, and it holds steady for as long as `pf_ready` stays low.

Top module: `stream_stride_prefetcher`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pf_valid` is low. The queue, the window tracker and the stride table all start empty.
- R2: Every prefetch output is a line address, equal to a byte address shifted right by 6 (64-byte lines).
- R3: Within one 4 KiB window, the first two ascending accesses produce no prefetch. The third strictly ascending access is the first to trigger.
- R4: Each window trigger at line L proposes line L+1 and then line L+2, in that order. Every later ascending access in the same window triggers again.
- R5: An access to a different 4 KiB window restarts the ascending count at one. So does a lower line in the same window. An access to the same line leaves the count unchanged.
- R6: The stride table has 8 entries, selected by `acc_ip[2:0]` and tagged with `acc_ip[15:3]`. Each entry holds a 2-bit confidence. An IP whose accesses keep a constant non-zero byte stride S first predicts on its 5th access, proposing the line of address+S. It then predicts on every further matching access.
- R7: A stride that differs from the stored one sets the confidence to zero and stores the new stride. Three more matching accesses are then needed before the next prediction.
- R8: IPs with different table indices train independently. An access whose IP maps to an occupied entry with a different tag replaces that entry and produces no prediction.
- R9: A proposal is dropped if its line equals one of the last 4 lines accepted into the queue, or an earlier proposal of the same cycle. Candidate order within a cycle is: window L+1, window L+2, then stride.
- R10: The queue holds 4 lines. Proposals that find it full are discarded and are not recorded as accepted. The demand input is never stalled.
- R11: Lines leave in the order they were accepted. While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` is stable.
- R12: A proposal made by an access at clock edge t is visible on `pf_valid`/`pf_line` right after edge t when the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_addr | input | 32 | Demand byte address |
| acc_ip | input | 16 | Instruction pointer of the demand access |
| pf_valid | output | 1 | Prefetch line available |
| pf_ready | input | 1 | Consumer takes the line on this edge |
| pf_line | output | 26 | Prefetch line address (byte address >> 6) |

## Verification
A wrong ascending count or window tag shows up as a line pair that arrives one access too early or too late. Because the queue is written on the same edge as the access, this is visible right after that edge. A damaged stride entry, such as a confidence counter that is not cleared or a stale tag, changes which access first produces a stride line. It can also produce a line at the wrong distance. Both effects are visible within the five accesses of training. Faults in the history filter or the queue pointers surface at the drain as duplicated, missing or reordered lines. Overfilling the queue with back-pressure applied shows whether discarded lines wrongly enter the history.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Number of candidate lines that can be proposed in one cycle:
  // two from the window detector, one from the stride table.
  localparam int PF_NCAND = 3;

  // Relation of an access to the tracked window.
  typedef enum logic [1:0] {
    WREL_NEW     = 2'd0,
    WREL_ASCEND  = 2'd1,
    WREL_SAME    = 2'd2,
    WREL_DESCEND = 2'd3
  } win_rel_e;
endpackage

// File: rtl/pf_stream_detect.sv
module pf_stream_detect
  import pf_pkg::*;
#(
  parameter int LINE_W    = 26,
  parameter int PAGE_SHFT = 6,   // line bits below the window number
  parameter int THRESH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  output logic              trig,
  output logic [LINE_W-1:0] line_a,
  output logic [LINE_W-1:0] line_b
);
  localparam int PAGE_W = LINE_W - PAGE_SHFT;
  localparam int CNT_W  = $clog2(THRESH + 1);

  logic              trk_valid;
  logic [PAGE_W-1:0] trk_page;
  logic [LINE_W-1:0] trk_line;
  logic [CNT_W-1:0]  trk_cnt;

  logic [PAGE_W-1:0] acc_page;
  win_rel_e          rel;
  logic [CNT_W-1:0]  cnt_nxt;

  assign acc_page = acc_line[LINE_W-1:PAGE_SHFT];

  always_comb begin
    if (!trk_valid || acc_page != trk_page) rel = WREL_NEW;
    else if (acc_line > trk_line)           rel = WREL_ASCEND;
    else if (acc_line == trk_line)          rel = WREL_SAME;
    else                                    rel = WREL_DESCEND;
  end

  always_comb begin
    unique case (rel)
      WREL_ASCEND: cnt_nxt = (trk_cnt < CNT_W'(THRESH)) ? trk_cnt + CNT_W'(1) : trk_cnt;
      WREL_SAME:   cnt_nxt = trk_cnt;
      default:     cnt_nxt = CNT_W'(1);
    endcase
  end

  assign trig   = acc_valid && (rel == WREL_ASCEND) && (cnt_nxt >= CNT_W'(THRESH));
  assign line_a = acc_line + LINE_W'(1);
  assign line_b = acc_line + LINE_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_valid <= 1'b0;
      trk_page  <= '0;
      trk_line  <= '0;
      trk_cnt   <= '0;
    end else if (acc_valid) begin
      trk_valid <= 1'b1;
      trk_page  <= acc_page;
      trk_line  <= acc_line;
      trk_cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pf_stride_table.sv
module pf_stride_table #(
  parameter int ADDR_W    = 32,
  parameter int IP_W      = 16,
  parameter int ENTRIES   = 8,
  parameter int CONF_W    = 2,
  parameter int LINE_BITS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_addr,
  input  logic [IP_W-1:0]             acc_ip,
  output logic                        pred,
  output logic [ADDR_W-LINE_BITS-1:0] pred_line
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = IP_W - IDX_W;
  localparam int LINE_W = ADDR_W - LINE_BITS;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic              ent_v      [ENTRIES];
  logic [TAG_W-1:0]  ent_tag    [ENTRIES];
  logic [ADDR_W-1:0] ent_last   [ENTRIES];
  logic [ADDR_W-1:0] ent_stride [ENTRIES];
  logic [CONF_W-1:0] ent_conf   [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit;
  logic              match;
  logic [ADDR_W-1:0] delta;
  logic [CONF_W-1:0] conf_nxt;

  assign idx   = acc_ip[IDX_W-1:0];
  assign tag   = acc_ip[IP_W-1:IDX_W];
  assign hit   = ent_v[idx] && (ent_tag[idx] == tag);
  assign delta = acc_addr - ent_last[idx];
  assign match = (delta == ent_stride[idx]);

  always_comb begin
    if (hit && match)
      conf_nxt = (ent_conf[idx] == CONF_MAX) ? CONF_MAX : ent_conf[idx] + CONF_W'(1);
    else
      conf_nxt = '0;
  end

  assign pred      = acc_valid && hit && match && (conf_nxt == CONF_MAX) && (delta != '0);
  assign pred_line = LINE_W'((acc_addr + delta) >> LINE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ent_v[e]      <= 1'b0;
        ent_tag[e]    <= '0;
        ent_last[e]   <= '0;
        ent_stride[e] <= '0;
        ent_conf[e]   <= '0;
      end
    end else if (acc_valid) begin
      ent_v[idx]    <= 1'b1;
      ent_tag[idx]  <= tag;
      ent_last[idx] <= acc_addr;
      ent_conf[idx] <= conf_nxt;
      if (hit) ent_stride[idx] <= delta;
      else     ent_stride[idx] <= '0;
    end
  end
endmodule

// File: rtl/pf_issue_queue.sv
module pf_issue_queue #(
  parameter int LINE_W = 26,
  parameter int NCAND  = 3,
  parameter int DEPTH  = 4,   // power of two
  parameter int HIST   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAND-1:0]  cand_v,
  input  logic [LINE_W-1:0] cand_line [NCAND],
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = $clog2(DEPTH + NCAND + 1);

  logic [LINE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rptr, wptr, wptr_nxt;
  logic [CNT_W-1:0]  cnt;
  logic [SUM_W-1:0]  fill_nxt;

  logic [LINE_W-1:0] hist_line [HIST];
  logic              hist_v    [HIST];
  logic [LINE_W-1:0] hl_nxt    [HIST];
  logic              hv_nxt    [HIST];

  logic [NCAND-1:0]  keep, take;
  logic [PTR_W-1:0]  slot [NCAND];
  logic              pop;

  // Duplicate filter against recent history and earlier candidates.
  always_comb begin
    for (int i = 0; i < NCAND; i++) begin
      logic dup;
      dup = 1'b0;
      for (int h = 0; h < HIST; h++)
        if (hist_v[h] && hist_line[h] == cand_line[i]) dup = 1'b1;
      for (int j = 0; j < NCAND; j++)
        if (j < i && cand_v[j] && cand_line[j] == cand_line[i]) dup = 1'b1;
      keep[i] = cand_v[i] && !dup;
    end
  end

  // Slot assignment; candidates that find no room are discarded.
  always_comb begin
    logic [SUM_W-1:0] used;
    logic [PTR_W-1:0] wp;
    used = SUM_W'(cnt);
    wp   = wptr;
    for (int i = 0; i < NCAND; i++) begin
      take[i] = keep[i] && (used < SUM_W'(DEPTH));
      slot[i] = wp;
      if (take[i]) begin
        used = used + SUM_W'(1);
        wp   = wp + PTR_W'(1);
      end
    end
    fill_nxt = used;
    wptr_nxt = wp;
  end

  // History of accepted lines, newest at index 0.
  always_comb begin
    hl_nxt = hist_line;
    hv_nxt = hist_v;
    for (int i = 0; i < NCAND; i++) begin
      if (take[i]) begin
        for (int k = HIST - 1; k > 0; k--) begin
          hl_nxt[k] = hl_nxt[k-1];
          hv_nxt[k] = hv_nxt[k-1];
        end
        hl_nxt[0] = cand_line[i];
        hv_nxt[0] = 1'b1;
      end
    end
  end

  assign pf_valid = (cnt != '0);
  assign pf_line  = mem[rptr];
  assign pop      = pf_valid && pf_ready;
  assign occ      = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
      for (int h = 0; h < HIST; h++) begin
        hist_line[h] <= '0;
        hist_v[h]    <= 1'b0;
      end
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else begin
      for (int i = 0; i < NCAND; i++)
        if (take[i]) mem[slot[i]] <= cand_line[i];
      if (pop) rptr <= rptr + PTR_W'(1);
      wptr      <= wptr_nxt;
      cnt       <= CNT_W'(fill_nxt - SUM_W'(pop));
      hist_line <= hl_nxt;
      hist_v    <= hv_nxt;
    end
  end
endmodule

// File: rtl/stream_stride_prefetcher.sv
module stream_stride_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int IP_W           = 16,
  parameter int LINE_BITS      = 6,
  parameter int WIN_BITS       = 12,
  parameter int STREAM_THRESH  = 3,
  parameter int STRIDE_ENTRIES = 8,
  parameter int CONF_W         = 2,
  parameter int QUEUE_DEPTH    = 4,
  parameter int DUP_WINDOW     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_addr,
  input  logic [IP_W-1:0]             acc_ip,
  output logic                        pf_valid,
  input  logic                        pf_ready,
  output logic [ADDR_W-LINE_BITS-1:0] pf_line
);
  localparam int LINE_W = ADDR_W - LINE_BITS;
  localparam int OCC_W  = $clog2(QUEUE_DEPTH + 1);

  logic              s_trig, t_pred;
  logic [LINE_W-1:0] s_line_a, s_line_b, t_line;
  logic [PF_NCAND-1:0] cand_v;
  logic [LINE_W-1:0] cand_line [PF_NCAND];
  logic [OCC_W-1:0]  q_occ;

  pf_stream_detect #(
    .LINE_W(LINE_W), .PAGE_SHFT(WIN_BITS - LINE_BITS), .THRESH(STREAM_THRESH)
  ) u_stream (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_line(acc_addr[ADDR_W-1:LINE_BITS]),
    .trig(s_trig), .line_a(s_line_a), .line_b(s_line_b)
  );

  pf_stride_table #(
    .ADDR_W(ADDR_W), .IP_W(IP_W), .ENTRIES(STRIDE_ENTRIES),
    .CONF_W(CONF_W), .LINE_BITS(LINE_BITS)
  ) u_stride (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_ip(acc_ip),
    .pred(t_pred), .pred_line(t_line)
  );

  // Candidate order sets duplicate priority: window pair first, then stride.
  assign cand_v       = {t_pred, s_trig, s_trig};
  assign cand_line[0] = s_line_a;
  assign cand_line[1] = s_line_b;
  assign cand_line[2] = t_line;

  pf_issue_queue #(
    .LINE_W(LINE_W), .NCAND(PF_NCAND), .DEPTH(QUEUE_DEPTH), .HIST(DUP_WINDOW)
  ) u_queue (
    .clk(clk), .rst_n(rst_n), .cand_v(cand_v), .cand_line(cand_line),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line), .occ(q_occ)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic                       pf_valid,
  input logic                       pf_ready,
  input logic [LINE_W-1:0]          pf_line,
  input logic [$clog2(DEPTH+1)-1:0] q_occ
);
  logic              seen_pop;
  logic [LINE_W-1:0] prev_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_pop <= 1'b0;
      prev_pop <= '0;
    end else if (pf_valid && pf_ready) begin
      seen_pop <= 1'b1;
      prev_pop <= pf_line;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !pf_valid); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) q_occ <= DEPTH); // R10
  AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line)); // R11
  AST_CAUSED_BY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(acc_valid)); // R12
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && seen_pop |-> pf_line != prev_pop); // R9
endmodule

bind stream_stride_prefetcher pf_checker #(
  .LINE_W(ADDR_W - LINE_BITS), .DEPTH(QUEUE_DEPTH)
) u_pf_checker (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_line(pf_line), .q_occ(q_occ)
);

// File: tb/stream_stride_prefetcher_bench.sv
module stream_stride_prefetcher_bench;
  localparam int LW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [31:0]   acc_addr = '0;
  logic [15:0]   acc_ip = '0;
  logic          pf_valid;
  logic          pf_ready = 1'b1;
  logic [LW-1:0] pf_line;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [LW-1:0] cap [32];
  int cap_n = 0;

  stream_stride_prefetcher u_stream_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_ip(acc_ip), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  always #5 clk = ~clk;

  // Record each line taken by the consumer, sampled mid-cycle.
  always @(negedge clk) begin
    #1;
    if (rst_n && pf_valid && pf_ready && cap_n < 32) begin
      cap[cap_n] = pf_line;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; pf_ready = 1'b1;
    repeat (2) @(negedge clk);
    cap_n = 0;
    rst_n = 1'b1;
    @(negedge clk); #2;
  endtask

  task automatic access(input logic [31:0] a, input logic [15:0] ip);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_ip = ip;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic drain();
    pf_ready = 1'b1;
    repeat (8) @(negedge clk);
    #2;
  endtask

  task automatic expect_caps(input string req, input int n, input logic [LW-1:0] e [6]);
    chk(cap_n == n, req, "captured line count", cap_n, n);
    for (int i = 0; i < n && i < cap_n; i++)
      chk(cap[i] == e[i], req, $sformatf("line %0d", i), cap[i], e[i]);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk(pf_valid == 1'b0, "R1", "pf_valid in reset", pf_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(pf_valid == 1'b0, "R1", "pf_valid after reset", pf_valid, 0);
  endtask

  // R3, R4, R9, R2: window trigger, line pair, duplicate drop
  task automatic t_stream();
    do_reset();
    access(32'h0001_0000, 16'h0001);
    access(32'h0001_0040, 16'h0002);
    drain();
    chk(cap_n == 0, "R3", "no prefetch before third access", cap_n, 0);
    access(32'h0001_0080, 16'h0003);
    drain();
    // R2: line 0x402 is byte 0x10080 >> 6; pair is 0x403, 0x404
    expect_caps("R4", 2, '{26'h403, 26'h404, 0, 0, 0, 0});
    access(32'h0001_00C0, 16'h0004);
    drain();
    expect_caps("R9", 3, '{26'h403, 26'h404, 26'h405, 0, 0, 0});
  endtask

  // R5: window change and descending access restart the count
  task automatic t_restart();
    do_reset();
    access(32'h0001_0000, 16'h0001);
    access(32'h0001_0040, 16'h0002);
    access(32'h0002_0000, 16'h0003);
    access(32'h0002_0040, 16'h0004);
    drain();
    chk(cap_n == 0, "R5", "new window restarts count", cap_n, 0);
    access(32'h0002_0080, 16'h0005);
    drain();
    expect_caps("R5", 2, '{26'h803, 26'h804, 0, 0, 0, 0});
    access(32'h0002_0040, 16'h0006);
    access(32'h0002_0000, 16'h0007);
    access(32'h0002_0040, 16'h0000);
    drain();
    chk(cap_n == 2, "R5", "descending restarts count", cap_n, 2);
  endtask

  // R6: stride prediction on fifth access, repeating after
  task automatic t_stride();
    do_reset();
    for (int k = 0; k < 4; k++) access(32'h0010_0000 + k * 32'h2040, 16'h0005);
    drain();
    chk(cap_n == 0, "R6", "no stride prediction before fifth access", cap_n, 0);
    access(32'h0010_0000 + 4 * 32'h2040, 16'h0005);
    drain();
    access(32'h0010_0000 + 5 * 32'h2040, 16'h0005);
    drain();
    expect_caps("R6", 2, '{26'h4285, 26'h4306, 0, 0, 0, 0});
  endtask

  // R7: stride change clears confidence
  task automatic t_mismatch();
    do_reset();
    for (int k = 0; k < 5; k++) access(32'h0020_0000 + k * 32'h2040, 16'h0006);
    access(32'h0020_B100, 16'h0006);
    access(32'h0020_E100, 16'h0006);
    access(32'h0021_1100, 16'h0006);
    drain();
    chk(cap_n == 1, "R7", "no prediction while retraining", cap_n, 1);
    access(32'h0021_4100, 16'h0006);
    drain();
    expect_caps("R7", 2, '{26'h8285, 26'h85C4, 0, 0, 0, 0});
  endtask

  // R8: independent IPs and tag replacement
  task automatic t_ips();
    do_reset();
    for (int k = 0; k < 5; k++) begin
      access(32'h0040_0000 + k * 32'h2040, 16'h0001);
      access(32'h0080_0000 + k * 32'h3040, 16'h0002);
    end
    drain();
    expect_caps("R8", 2, '{26'h10285, 26'h203C5, 0, 0, 0, 0});
    do_reset();
    for (int k = 0; k < 4; k++) access(32'h0010_0000 + k * 32'h2040, 16'h0005);
    access(32'h0090_0000, 16'h000D);
    access(32'h0010_0000 + 4 * 32'h2040, 16'h0005);
    drain();
    chk(cap_n == 0, "R8", "aliased IP replaced entry", cap_n, 0);
  endtask

  // R10, R11: full queue drops, stall holds output
  task automatic t_full();
    do_reset();
    pf_ready = 1'b0;
    for (int k = 0; k < 6; k++) access(32'h0001_0000 + k * 32'h40, 16'(k + 1));
    #1;
    chk(pf_valid == 1'b1, "R11", "valid held under stall", pf_valid, 1);
    chk(pf_line == 26'h403, "R11", "head line under stall", pf_line, 26'h403);
    repeat (3) @(negedge clk);
    #1;
    chk(pf_line == 26'h403, "R11", "head line stable", pf_line, 26'h403);
    drain();
    expect_caps("R10", 4, '{26'h403, 26'h404, 26'h405, 26'h406, 0, 0});
    access(32'h0001_0180, 16'h0007);
    drain();
    expect_caps("R10", 6, '{26'h403, 26'h404, 26'h405, 26'h406, 26'h407, 26'h408});
  endtask

  // R12: one-edge latency
  task automatic t_latency();
    do_reset();
    access(32'h0001_0000, 16'h0001);
    access(32'h0001_0040, 16'h0002);
    @(negedge clk);
    chk(pf_valid == 1'b0, "R12", "idle before trigger", pf_valid, 0);
    acc_valid = 1'b1; acc_addr = 32'h0001_0080; acc_ip = 16'h0003;
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    chk(pf_valid == 1'b1, "R12", "valid right after trigger edge", pf_valid, 1);
    chk(pf_line == 26'h403, "R12", "line right after trigger edge", pf_line, 26'h403);
    drain();
  endtask

  initial begin
    t_reset();
    t_stream();
    t_restart();
    t_stride();
    t_mismatch();
    t_ips();
    t_full();
    t_latency();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule